// File: doc/BRIEF.md
# Dual-Rail Four-Phase Channel Receiver

This block receives words from a dual-rail, four-phase handshake channel. Every data bit travels on two wires, a true rail and a false rail. Between words the sender brings all wires back to the empty (spacer) state. The receiver runs on a clock and assumes its inputs are already synchronized to that clock. It classifies the pair of wires for each bit. A reduction tree then decides when every bit holds a legal value. At that point the receiver captures the decoded word, gives a one-cycle valid pulse and raises its single acknowledge wire.

A second tree watches for the whole word to return to spacer, and the acknowledge falls only after that. There is no request wire. Validity comes only from the codewords themselves, and each bit may arrive in any order and at any time.

The receiver guards the channel. A pair with both rails high is an illegal code. A bit that moves against the current handshake phase is a protocol error. Either one sets a sticky error flag, which holds the acknowledge low and blocks all capture until reset.

Top module: `dr_chan_rx`

## Requirements
- R1: Bit codes as (true, false) are 00 spacer, 01 logical 0 and 10 logical 1. A captured bit of `word_out` equals the true rail of that pair.
- R2: `ack` rises, and `word_vld` pulses for exactly one cycle, in the cycle after the first clock edge at which every bit pair holds 01 or 10.
- R3: While any bit pair is still at 00, the word is not captured: `ack` stays 0 and `word_vld` stays 0.
- R4: `ack` falls in the cycle after the first edge at which every pair is back at 00. A word that is only partly back at spacer keeps `ack` at 1.
- R5: A word held valid for many cycles produces one `word_vld` pulse only. A new capture needs a full return to spacer and a fall of `ack` first.
- R6: A pair showing 11 sets `err` in the next cycle. `err` then stays 1 until reset.
- R7: While `err` is 1, `ack` is 0 and `word_vld` never pulses, even for a complete word.
- R8: With `ack` at 0, a valid pair that changes (back to spacer or to the other value) sets `err`. With `ack` at 1, a pair at spacer that leaves spacer sets `err`.
- R9: After a synchronous reset, `ack`, `word_vld`, `err` and `word_out` are all 0.
- R10: `word_out` holds the last captured word until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_t | input | WIDTH | True rail of each bit |
| rail_f | input | WIDTH | False rail of each bit |
| ack | output | 1 | Channel acknowledge, registered |
| word_out | output | WIDTH | Last captured decoded word |
| word_vld | output | 1 | One-cycle pulse when a word is captured |
| err | output | 1 | Sticky illegal-code or protocol error flag |

## Verification
A wrong phase register shows at the ports within one cycle of the mistake. Depending on the error, the acknowledge rises on a partial word, stays high after a full spacer, or gives a second valid pulse while the data is held. A stale per-bit history in the monotonicity check shows up differently. Either `err` is raised on a legal return to spacer, or no error appears after a bit goes back and forth during the acknowledge-high phase. A lost or cleared error flag shows as a capture or a high acknowledge while the channel is poisoned. The bench compares all four outputs every cycle against its own cycle model, so each of these faults is reported in the cycle in which it first appears.

// File: rtl/dr_pkg.sv
package dr_pkg;

  typedef enum logic [1:0] {
    SYM_SPACER = 2'b00,
    SYM_ZERO   = 2'b01,
    SYM_ONE    = 2'b10,
    SYM_BAD    = 2'b11
  } dr_sym_e;

  typedef struct packed {
    logic empty;
    logic legal;
    logic bad;
    logic value;
  } dr_bit_t;

  function automatic dr_bit_t classify(input logic t, input logic f);
    dr_bit_t r;
    r = '0;
    unique case (dr_sym_e'({t, f}))
      SYM_SPACER: r.empty = 1'b1;
      SYM_ZERO:   r.legal = 1'b1;
      SYM_ONE:    begin r.legal = 1'b1; r.value = 1'b1; end
      SYM_BAD:    r.bad = 1'b1;
      default:    r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dr_bit_decode.sv
module dr_bit_decode #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic [WIDTH-1:0] empty,
  output logic [WIDTH-1:0] legal,
  output logic [WIDTH-1:0] bad,
  output logic [WIDTH-1:0] value
);
  import dr_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    dr_bit_t cls;
    always_comb cls = classify(rail_t[i], rail_f[i]);
    assign empty[i] = cls.empty;
    assign legal[i] = cls.legal;
    assign bad[i]   = cls.bad;
    assign value[i] = cls.value;
  end
endmodule

// File: rtl/dr_and_tree.sv
module dr_and_tree #(
  parameter int N = 8
) (
  input  logic [N-1:0] leaves,
  output logic         all_set
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
  localparam int SLOTS  = 1 << LEVELS;

  logic node [1:2*SLOTS-1];

  for (genvar i = 0; i < SLOTS; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign node[SLOTS+i] = leaves[i];
    end else begin : g_pad
      assign node[SLOTS+i] = 1'b1;
    end
  end

  for (genvar j = 1; j < SLOTS; j++) begin : g_join
    assign node[j] = node[2*j] & node[2*j+1];
  end

  assign all_set = node[1];
endmodule

// File: rtl/dr_mono_check.sv
module dr_mono_check #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_phase,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             violation
);
  logic [WIDTH-1:0] prev_t;
  logic [WIDTH-1:0] prev_f;
  logic [WIDTH-1:0] bit_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_t <= '0;
      prev_f <= '0;
    end else begin
      prev_t <= rail_t;
      prev_f <= rail_f;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic was_empty;
    logic was_legal;
    logic moved;
    always_comb begin
      was_empty  = ~(prev_t[i] | prev_f[i]);
      was_legal  = prev_t[i] ^ prev_f[i];
      moved      = (prev_t[i] != rail_t[i]) || (prev_f[i] != rail_f[i]);
      bit_bad[i] = ack_phase ? (was_empty & moved) : (was_legal & moved);
    end
  end

  assign violation = |bit_bad;
endmodule

// File: rtl/dr_chan_rx.sv
module dr_chan_rx #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             ack,
  output logic [WIDTH-1:0] word_out,
  output logic             word_vld,
  output logic             err
);
  logic [WIDTH-1:0] empty_v;
  logic [WIDTH-1:0] legal_v;
  logic [WIDTH-1:0] bad_v;
  logic [WIDTH-1:0] value_v;
  logic             complete;
  logic             drained;
  logic             order_viol;
  logic             ack_q;
  logic             vld_q;
  logic             err_q;
  logic [WIDTH-1:0] word_q;
  logic             err_nxt;
  logic             take;
  logic             release_ack;

  dr_bit_decode #(.WIDTH(WIDTH)) i_decode (
    .rail_t (rail_t),
    .rail_f (rail_f),
    .empty  (empty_v),
    .legal  (legal_v),
    .bad    (bad_v),
    .value  (value_v)
  );

  dr_and_tree #(.N(WIDTH)) i_done_tree (
    .leaves  (legal_v),
    .all_set (complete)
  );

  dr_and_tree #(.N(WIDTH)) i_empty_tree (
    .leaves  (empty_v),
    .all_set (drained)
  );

  dr_mono_check #(.WIDTH(WIDTH)) i_mono (
    .clk       (clk),
    .rst       (rst),
    .ack_phase (ack_q),
    .rail_t    (rail_t),
    .rail_f    (rail_f),
    .violation (order_viol)
  );

  always_comb begin
    err_nxt     = err_q | (|bad_v) | order_viol;
    take        = ~ack_q & ~err_q & complete & ~order_viol;
    release_ack = ack_q & drained;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      word_q <= '0;
    end else begin
      err_q <= err_nxt;
      vld_q <= take;
      if (take) word_q <= value_v;
      if (err_nxt)          ack_q <= 1'b0;
      else if (take)        ack_q <= 1'b1;
      else if (release_ack) ack_q <= 1'b0;
    end
  end

  assign ack      = ack_q;
  assign word_vld = vld_q;
  assign err      = err_q;
  assign word_out = word_q;
endmodule

// File: rtl/dr_chan_rx_chk.sv
module dr_chan_rx_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] rail_t,
  input logic [WIDTH-1:0] rail_f,
  input logic             ack,
  input logic [WIDTH-1:0] word_out,
  input logic             word_vld,
  input logic             err
);
  assert_ack_rise_complete_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(&(rail_t ^ rail_f)));

  assert_vld_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (ack && !$past(ack)));

  assert_vld_single_R5: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  assert_ack_fall_drained_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> ($past((rail_t | rail_f) == '0) || err));

  assert_bad_code_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (|(rail_t & rail_f)) |=> err);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_err_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> (!ack && !word_vld));

  assert_word_capture_R1: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (word_out == $past(rail_t)));

  assert_word_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_out));
endmodule

bind dr_chan_rx dr_chan_rx_chk #(.WIDTH(WIDTH)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .rail_t   (rail_t),
  .rail_f   (rail_f),
  .ack      (ack),
  .word_out (word_out),
  .word_vld (word_vld),
  .err      (err)
);

// File: tb/test_dr_chan_rx.sv
module test_dr_chan_rx;
  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] rail_t = '0;
  logic [W-1:0] rail_f = '0;
  logic         ack;
  logic [W-1:0] word_out;
  logic         word_vld;
  logic         err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic         m_ack = 0, m_vld = 0, m_err = 0;
  logic [W-1:0] m_word = '0, m_pt = '0, m_pf = '0;

  dr_chan_rx #(.WIDTH(W)) i_dr_chan_rx (
    .clk(clk), .rst(rst), .rail_t(rail_t), .rail_f(rail_f),
    .ack(ack), .word_out(word_out), .word_vld(word_vld), .err(err)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic order_bad(input logic [W-1:0] t, input logic [W-1:0] f);
    logic r = 0;
    for (int i = 0; i < W; i++) begin
      if (m_ack) r |= !(m_pt[i] | m_pf[i]) && (t[i] | f[i]);
      else       r |= (m_pt[i] ^ m_pf[i]) && ((t[i] != m_pt[i]) || (f[i] != m_pf[i]));
    end
    return r;
  endfunction

  // One clock: drive at negedge, predict, compare just after the posedge.
  task automatic step(input logic [W-1:0] t, input logic [W-1:0] f);
    logic en, tk, rl, ov;
    @(negedge clk);
    rail_t = t;
    rail_f = f;
    ov = order_bad(t, f);
    en = m_err | (|(t & f)) | ov;
    tk = !m_ack && !m_err && (&(t ^ f)) && !ov;
    rl = m_ack && ((t | f) == '0);
    @(posedge clk);
    if (rst) begin
      m_ack = 0; m_vld = 0; m_err = 0; m_word = '0; m_pt = '0; m_pf = '0;
    end else begin
      m_err = en;
      m_vld = tk;
      if (tk) m_word = t;
      if (en) m_ack = 0;
      else if (tk) m_ack = 1;
      else if (rl) m_ack = 0;
      m_pt = t; m_pf = f;
    end
    #1;
    chk("R4 ack", ack, m_ack);
    chk("R2 word_vld", word_vld, m_vld);
    chk("R6 err", err, m_err);
    chk("R1 word_out", word_out, m_word);
  endtask

  task automatic do_reset();
    rst = 1;
    step('0, '0);
    step('0, '0);
    rst = 0;
  endtask

  // Bits arrive in random order, are held, then drain in random order.
  task automatic send_word(input logic [W-1:0] d, input bit inject);
    logic [W-1:0] mask = '0;
    int guard = 0;
    while (mask != '1) begin
      logic [W-1:0] pick = W'($urandom);
      mask |= pick & W'($urandom);
      if (guard++ > 6) mask = '1;
      if (inject && mask != '1 && ($urandom % 4 == 0)) begin
        step((d & mask) | W'(1), (~d & mask) | W'(1));
        return;
      end
      step(d & mask, ~d & mask);
    end
    for (int k = 0; k < int'($urandom % 3) + 1; k++) step(d, ~d);
    guard = 0;
    while (mask != '0) begin
      mask &= W'($urandom);
      if (guard++ > 6) mask = '0;
      step(d & mask, ~d & mask);
    end
    step('0, '0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'h5eed_c0de));
    do_reset();
    // R9: reset state
    chk("R9 ack", ack, 0); chk("R9 vld", word_vld, 0);
    chk("R9 err", err, 0); chk("R9 word", word_out, 0);

    // R3: partial word never captured
    d = 8'hA5;
    for (int k = 0; k < 4; k++) step(d & 8'h7F, ~d & 8'h7F);
    chk("R3 ack partial", ack, 0);
    chk("R3 vld partial", word_vld, 0);
    step(d, ~d);
    chk("R2 vld on complete", word_vld, 1);
    chk("R1 decoded word", word_out, 32'hA5);
    // R5: holding valid data gives no further pulse
    for (int k = 0; k < 5; k++) begin
      step(d, ~d);
      chk("R5 no repeat pulse", word_vld, 0);
    end
    // R4: partial drain keeps ack high
    for (int k = 0; k < 3; k++) step(d & 8'h01, ~d & 8'h01);
    chk("R4 ack held on partial drain", ack, 1);
    step('0, '0);
    chk("R4 ack falls after full drain", ack, 0);
    // R10: word held while next word is partial
    step(8'h01, 8'h00);
    chk("R10 word held", word_out, 32'hA5);
    step('0, '0);
    chk("R8 ack-low retreat flagged", err, 1);
    do_reset();

    // R8 + R7: spacer bit re-rising while ack high
    d = 8'h3C;
    step(d, ~d); step(d, ~d);
    step(d & 8'hFE, ~d & 8'hFE);
    step(d, ~d);
    chk("R8 ack-high re-rise flagged", err, 1);
    chk("R7 ack forced low", ack, 0);
    do_reset();

    // R6 + R7: illegal code poisons the channel
    step(8'h10, 8'h10);
    chk("R6 illegal sets err", err, 1);
    step('0, '0);
    step(8'h0F, 8'hF0);
    chk("R7 no capture while err", word_vld, 0);
    step(8'h0F, 8'hF0);
    chk("R7 ack low while err", ack, 0);
    chk("R6 err sticky", err, 1);
    do_reset();
    chk("R9 err cleared", err, 0);

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      bit inj = ($urandom % 30 == 0);
      send_word(W'($urandom), inj);
      if (m_err) do_reset();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule